// File: doc/BRIEF.md
# Bidirectional Running Light Controller

This block drives an LED word in which exactly one bit is lit. The lit bit moves one position each time a down-counting delay interval runs out, which gives a running light. On every move the word is rotated by one bit, so the light wraps from one end of the word to the other. After reset the light starts on the least significant bit and moves toward the most significant bit.

Two clean single-cycle event strobes control the light. A reverse event turns the direction of travel around. A stop event freezes the light where it is and raises a halted flag, and both stay that way until the next reset. The delay between moves is set by a reload input that the counter loads each time it expires. The first interval after reset uses a parameter whose default is FFFFh.

Top module: `led_run_top`

## Requirements
- R1: While reset is asserted and right after it is released, `ledOut` is 00000001b (bit 0 lit), `halted` is 0 and the direction is upward.
- R2: Upward movement is a rotate-left by one bit, so bit 7 lit is followed by bit 0 lit.
- R3: Downward movement is a rotate-right by one bit, so bit 0 lit is followed by bit 7 lit.
- R4: Each `reverseEvt` pulse inverts the direction. The pulse leaves the current `ledOut` unchanged. A move in the same cycle as the pulse still uses the old direction, and the new direction applies from the following move onward.
- R5: A `stopEvt` pulse sets `halted` to 1 on the next clock edge. From then until reset, `ledOut` never changes and `reverseEvt` has no effect.
- R6: After reset the first move comes at the (DEFAULT_RELOAD+1)-th clock edge. Each later move comes delayReload+1 edges after the previous one. DEFAULT_RELOAD defaults to FFFFh.
- R7: When `stopEvt` coincides with `reverseEvt` or with a due move, the stop wins: no move is made and the light halts.
- R8: Out of reset, `ledOut` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reverseEvt | input | 1 | Single-cycle strobe that turns the direction around |
| stopEvt | input | 1 | Single-cycle strobe that freezes the light until reset |
| delayReload | input | DELAY_WIDTH (16) | Interval reload value loaded each time the counter expires |
| ledOut | output | LED_WIDTH (8) | One-hot LED word |
| halted | output | 1 | High once the light has been stopped |

## Verification
A move that falls due and a stop event can land in the same cycle, and a reverse event can land on that same cycle too. The bench times its pulses from the known move period. It raises a reverse pulse exactly on a move edge and checks that the move keeps the old direction. It then raises stop and reverse together on a move edge and checks that the word stays put and halted rises. Checker properties on the word's stability after a stop back up these directed checks.

// File: rtl/led_run_pkg.sv
package led_run_pkg;
  // Strobes passed from the control section to the datapath
  typedef struct packed {
    logic step;    // advance the light this cycle
    logic moveUp;  // direction used by the advance: 1 = rotate left
  } ledCtrl_t;
endpackage

// File: rtl/led_run_ctrl.sv
module led_run_ctrl
  import led_run_pkg::*;
#(
  parameter int unsigned DELAY_WIDTH = 16,
  parameter logic [DELAY_WIDTH-1:0] DEFAULT_RELOAD = '1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reverseEvt,
  input  logic                   stopEvt,
  input  logic [DELAY_WIDTH-1:0] delayReload,
  output ledCtrl_t               ctrl,
  output logic                   halted
);
  logic [DELAY_WIDTH-1:0] delayCnt;
  logic                   dirUp;
  logic                   haltQ;
  logic                   expired;

  assign expired = (delayCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayCnt <= DEFAULT_RELOAD;
      dirUp    <= 1'b1;
      haltQ    <= 1'b0;
    end else if (!haltQ) begin
      if (stopEvt) begin
        // stop wins over reverse and over a due step
        haltQ <= 1'b1;
      end else begin
        if (reverseEvt) dirUp <= ~dirUp;
        if (expired) delayCnt <= delayReload;
        else         delayCnt <= delayCnt - 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.step   = expired && !haltQ && !stopEvt;
    ctrl.moveUp = dirUp;
  end

  assign halted = haltQ;
endmodule

// File: rtl/led_run_datapath.sv
module led_run_datapath
  import led_run_pkg::*;
#(
  parameter int unsigned LED_WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ledCtrl_t             ctrl,
  output logic [LED_WIDTH-1:0] ledOut
);
  localparam int unsigned TOP = LED_WIDTH - 1;

  logic [LED_WIDTH-1:0] ledQ;
  logic [LED_WIDTH-1:0] rotLeft;
  logic [LED_WIDTH-1:0] rotRight;

  // one-bit rotations, with wrap at both ends
  for (genvar i = 0; i < LED_WIDTH; i++) begin : g_rot
    assign rotLeft[i]  = ledQ[(i + TOP) % LED_WIDTH];
    assign rotRight[i] = ledQ[(i + 1) % LED_WIDTH];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledQ <= LED_WIDTH'(1);
    end else if (ctrl.step) begin
      ledQ <= ctrl.moveUp ? rotLeft : rotRight;
    end
  end

  assign ledOut = ledQ;
endmodule

// File: rtl/led_run_top.sv
module led_run_top
  import led_run_pkg::*;
#(
  parameter int unsigned LED_WIDTH = 8,
  parameter int unsigned DELAY_WIDTH = 16,
  parameter logic [DELAY_WIDTH-1:0] DEFAULT_RELOAD = 16'hFFFF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reverseEvt,
  input  logic                   stopEvt,
  input  logic [DELAY_WIDTH-1:0] delayReload,
  output logic [LED_WIDTH-1:0]   ledOut,
  output logic                   halted
);
  ledCtrl_t ctrlLink;

  led_run_ctrl #(
    .DELAY_WIDTH   (DELAY_WIDTH),
    .DEFAULT_RELOAD(DEFAULT_RELOAD)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reverseEvt (reverseEvt),
    .stopEvt    (stopEvt),
    .delayReload(delayReload),
    .ctrl       (ctrlLink),
    .halted     (halted)
  );

  led_run_datapath #(
    .LED_WIDTH(LED_WIDTH)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrlLink),
    .ledOut(ledOut)
  );
endmodule

// File: rtl/led_run_checker.sv
module led_run_checker #(
  parameter int unsigned LED_WIDTH = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reverseEvt,
  input logic                 stopEvt,
  input logic [LED_WIDTH-1:0] ledOut,
  input logic                 halted
);
  function automatic logic [LED_WIDTH-1:0] rotL(input logic [LED_WIDTH-1:0] v);
    return {v[LED_WIDTH-2:0], v[LED_WIDTH-1]};
  endfunction

  function automatic logic [LED_WIDTH-1:0] rotR(input logic [LED_WIDTH-1:0] v);
    return {v[0], v[LED_WIDTH-1:1]};
  endfunction

  // R8: exactly one lit bit
  p_one_lit_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ledOut) == 1);

  // R2 / R3: any change is a single-bit rotation one way or the other
  p_rotate_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ledOut) |-> (ledOut == rotL($past(ledOut)) || ledOut == rotR($past(ledOut))));

  // R5: a stop raises halted on the next edge
  p_stop_halts_r5: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |=> halted);

  // R5: halted is sticky and the word is frozen
  p_halt_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(ledOut)));

  // R7: a stop blocks any move in its own cycle
  p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |=> $stable(ledOut));

  // R4: a reverse pulse on its own never makes a move that is not a rotation
  p_reverse_no_jump_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reverseEvt && !halted) |=> ($stable(ledOut) || ledOut == rotL($past(ledOut))
                                 || ledOut == rotR($past(ledOut))));
endmodule

bind led_run_top led_run_checker #(.LED_WIDTH(LED_WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reverseEvt(reverseEvt),
  .stopEvt   (stopEvt),
  .ledOut    (ledOut),
  .halted    (halted)
);

// File: tb/led_run_top_bench.sv
module led_run_top_bench;
  localparam int unsigned LW = 8;
  localparam int unsigned DW = 16;
  localparam logic [DW-1:0] FIRST_DELAY = 16'd4;   // first move at edge 5
  localparam logic [DW-1:0] RUN_DELAY   = 16'd2;   // a move every 3 edges

  // {reverse pulse before this period, expected word after the period}
  localparam logic [8:0] VEC [14] = '{
    9'h004, 9'h008, 9'h010, 9'h020, 9'h040, 9'h080, 9'h001,
    9'h002, 9'h101, 9'h080, 9'h040, 9'h180, 9'h001, 9'h002
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reverseEvt = 1'b0;
  logic          stopEvt = 1'b0;
  logic [DW-1:0] delayReload = RUN_DELAY;
  logic [LW-1:0] ledOut;
  logic          halted;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  led_run_top #(
    .LED_WIDTH(LW),
    .DELAY_WIDTH(DW),
    .DEFAULT_RELOAD(FIRST_DELAY)
  ) u_led_run_top (
    .clk        (clk),
    .rstN       (rstN),
    .reverseEvt (reverseEvt),
    .stopEvt    (stopEvt),
    .delayReload(delayReload),
    .ledOut     (ledOut),
    .halted     (halted)
  );

  task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    edges(3);
    rstN = 1'b1;
    check("R1 led after reset", ledOut, 8'h01);
    check("R1 halted after reset", {7'd0, halted}, 8'h00);
  endtask

  initial begin
    logic [LW-1:0] prev;
    edges(1);
    doReset();
    // R6: first move at edge FIRST_DELAY+1
    edges(4);
    check("R6 no early move", ledOut, 8'h01);
    edges(1);
    check("R6 first move", ledOut, 8'h02);

    // table walk: R2, R3, R4, R6
    prev = 8'h02;
    for (int i = 0; i < 14; i++) begin
      reverseEvt = VEC[i][8];
      edges(1);
      reverseEvt = 1'b0;
      check("R4 word held between moves", ledOut, prev);
      edges(2);
      check("R2/R3 rotation step", ledOut, VEC[i][7:0]);
      prev = VEC[i][7:0];
    end

    // R4: reverse on a move edge, move keeps old direction (up)
    edges(2);
    reverseEvt = 1'b1;
    edges(1);
    reverseEvt = 1'b0;
    check("R4 move uses old direction", ledOut, 8'h04);
    edges(3);
    check("R4 next move uses new direction", ledOut, 8'h02);

    // R7: stop and reverse together on a move edge
    edges(2);
    stopEvt = 1'b1;
    reverseEvt = 1'b1;
    edges(1);
    stopEvt = 1'b0;
    reverseEvt = 1'b0;
    check("R7 no move on stop", ledOut, 8'h02);
    check("R7 halted on stop", {7'd0, halted}, 8'h01);

    // R5: reverse ignored after halt, word frozen
    edges(10);
    reverseEvt = 1'b1;
    edges(1);
    reverseEvt = 1'b0;
    edges(8);
    check("R5 word frozen", ledOut, 8'h02);
    check("R5 halted sticky", {7'd0, halted}, 8'h01);

    // R5: plain stop right after reset
    doReset();
    stopEvt = 1'b1;
    edges(1);
    stopEvt = 1'b0;
    check("R5 halted after stop", {7'd0, halted}, 8'h01);
    edges(20);
    check("R5 frozen after stop", ledOut, 8'h01);
    check("R8 one lit bit", {7'd0, ($countones(ledOut) == 1)}, 8'h01);

    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule